// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a small bank of control and status registers for a workstation I/O controller. Software reaches seven registers through one-hot select lines with a shared write strobe, read strobe and data bus. The registers are a configuration byte, a diagnostic byte, a modem-control byte, two auxiliary bytes, a 16-bit LED word and a 32-bit system-control word. Several registers act on other logic when written. A strobe bit on the first auxiliary register sends a terminal-count pulse to a floppy controller. The second auxiliary register requests power-off and acknowledges a power-fail interrupt. Setting the low bit of the system-control word requests a system reset.

A power-fail input from the supply monitor sets a sticky power-fail flag, but only while the enable bit in the configuration register is set. The interrupt output is the AND of that flag and the same enable bit. A soft-reset input returns the configuration, modem and both auxiliary registers to zero. It leaves the diagnostic, LED and system-control registers alone, so firmware can leave notes that survive a warm restart. The power-on reset `rst_n` clears everything.

Top module: `aux_sysctl_regs`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register reads 0 and `pwr_irq`, `fdc_tc_pulse`, `pwr_off_req` and `sys_reset_req` are low.
- R2: The select bits are: bit 0 configuration, bit 1 diagnostic, bit 2 modem, bit 3 aux1, bit 4 aux2, bit 5 LED, bit 6 system control. A read with `rd_en` returns, one cycle later, the value the selected register held before that clock edge, zero-extended to 32 bits. In a cycle without `rd_en`, `rdata` is 0 the next cycle. Configuration, diagnostic and modem store `wdata[7:0]`. LED stores `wdata[15:0]`.
- R3: A write to aux1 stores `wdata[7:0]` with bit 1 forced to 0. When `wdata[1]` is 1, `fdc_tc_pulse` is high for exactly the next cycle.
- R4: A write to aux2 stores `wdata[0]` as the power-off bit. Bits 1–4, 6 and 7 always read 0. The power-fail flag (bit 5) keeps its value unless `wdata[1]` is 1, which clears it.
- R5: A write to aux2 with `wdata[0]` = 1 makes `pwr_off_req` high for exactly the next cycle.
- R6: When `pwr_fail_in` differs from its value in the previous cycle, the flag becomes `pwr_fail_in` AND configuration bit 3. Bit 3 is taken as it stood before that edge.
- R7: `pwr_irq` is high exactly when the power-fail flag and configuration bit 3 are both 1.
- R8: A write to system control with `wdata[0]` = 1 loads 0x02 and makes `sys_reset_req` high for exactly the next cycle. A write with `wdata[0]` = 0 changes nothing.
- R9: A cycle with `soft_rst` high clears configuration, modem, aux1 and aux2, keeps diagnostic, LED and system control, and drops any write presented in that cycle.
- R10: When a power-fail input change and an aux2 write with the clear bit fall in the same cycle, the input change sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| sel | input | 7 | One-hot register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| pwr_fail_in | input | 1 | Power-fail indication from the supply monitor |
| pwr_irq | output | 1 | Power-fail interrupt |
| fdc_tc_pulse | output | 1 | Floppy terminal-count strobe |
| pwr_off_req | output | 1 | Power-off request pulse |
| sys_reset_req | output | 1 | System-reset request pulse |

## Verification
Directed sequences exercise the side-effect bits in isolation. An all-ones aux1 write separates a stored strobe bit from a dropped one. Aux2 writes with and without the clear bit separate a sticky flag from a writable one. Power-fail edges taken with the enable bit off and then on show whether the gate is sampled at the input change or only at the output.

A coincident clear and input edge pins down which of the two wins. A soft reset followed by reads of all seven registers separates the registers that survive a warm restart from those that are cleared. The same sequence checks that a write arriving during the soft reset is dropped.

Seeded random traffic then mixes single-register reads and writes, read-during-write, input toggles and occasional soft resets. Every output is compared against a bench model each cycle.

// File: rtl/aux_sysctl_pkg.sv
// Package: shared register indices and bit positions for the auxiliary
// system control register block. Assumes one-hot select in index order.
package aux_sysctl_pkg;
    localparam int NUM_REGS   = 7;
    localparam int IDX_CFG    = 0;
    localparam int IDX_DIAG   = 1;
    localparam int IDX_MODEM  = 2;
    localparam int IDX_AUX1   = 3;
    localparam int IDX_AUX2   = 4;
    localparam int IDX_LED    = 5;
    localparam int IDX_SYSCTL = 6;

    localparam int CFG_EN_BIT    = 3;  // power-fail interrupt enable
    localparam int AUX1_TC_BIT   = 1;  // terminal-count strobe, never stored
    localparam int AUX2_OFF_BIT  = 0;  // power-off request
    localparam int AUX2_CLR_BIT  = 1;  // power-fail acknowledge, never stored
    localparam int AUX2_FLAG_BIT = 5;  // sticky power-fail flag
    localparam int SYS_RST_BIT   = 0;  // reset request trigger
    localparam logic [7:0] SYS_STAT_VAL = 8'h02;  // value after reset request
endpackage

// File: rtl/aux_byte_regs.sv
// Module: configuration, diagnostic, modem and aux1 byte registers plus the
// terminal-count strobe. Assumes write strobes arrive already decoded and
// already gated by soft reset; soft_rst only clears the soft-clearable ones.
module aux_byte_regs #(
    parameter int BYTE_W = 8,
    parameter int TC_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_cfg,
    input  logic              wr_diag,
    input  logic              wr_modem,
    input  logic              wr_aux1,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] cfg_q,
    output logic [BYTE_W-1:0] diag_q,
    output logic [BYTE_W-1:0] modem_q,
    output logic [BYTE_W-1:0] aux1_q,
    output logic              tc_pulse
);
    localparam int          NPLAIN   = 3;
    localparam logic [2:0]  SOFT_CLR = 3'b101;  // cfg and modem clear, diag keeps
    localparam logic [BYTE_W-1:0] AUX1_MASK = ~(BYTE_W'(1) << TC_BIT);

    logic [NPLAIN-1:0] wr_plain;
    logic [BYTE_W-1:0] q_plain [NPLAIN];

    assign wr_plain = {wr_modem, wr_diag, wr_cfg};

    for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
        // Plain byte register; soft reset clears it only when marked.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_plain[g] <= '0;
            else if (SOFT_CLR[g] && soft_rst)
                q_plain[g] <= '0;
            else if (wr_plain[g])
                q_plain[g] <= wbyte;
        end
    end

    assign cfg_q   = q_plain[0];
    assign diag_q  = q_plain[1];
    assign modem_q = q_plain[2];

    // Aux1 storage with the strobe bit stripped.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            aux1_q <= '0;
        else if (wr_aux1)
            aux1_q <= wbyte & AUX1_MASK;
    end

    // One-cycle terminal-count pulse after a strobe write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tc_pulse <= 1'b0;
        else
            tc_pulse <= wr_aux1 & wbyte[TC_BIT];
    end
endmodule

// File: rtl/aux_pwr_ctl.sv
// Module: aux2 power control register, sticky power-fail flag, interrupt
// gating and power-off pulse. Assumes pwr_fail_in is synchronous to clk and
// wr_aux2 is already gated by soft reset. An input change overrides a clear.
module aux_pwr_ctl #(
    parameter int BYTE_W   = 8,
    parameter int OFF_BIT  = 0,
    parameter int CLR_BIT  = 1,
    parameter int FLAG_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_aux2,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              pf_in,
    input  logic              cfg_en,
    output logic [BYTE_W-1:0] aux2_q,
    output logic              irq,
    output logic              off_pulse
);
    logic pf_prev, pf_evt;
    logic off_q, flag_q;
    logic off_d, flag_d;

    assign pf_evt = pf_in ^ pf_prev;

    // Track the last input level to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pf_prev <= 1'b0;
        else
            pf_prev <= pf_in;
    end

    // Next value of the power-off bit and the flag.
    always_comb begin
        off_d  = off_q;
        flag_d = flag_q;
        if (wr_aux2) begin
            off_d = wbyte[OFF_BIT];
            if (wbyte[CLR_BIT])
                flag_d = 1'b0;
        end
        if (pf_evt)
            flag_d = pf_in & cfg_en;
    end

    // Stored aux2 state; soft reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            off_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            off_q  <= off_d;
            flag_q <= flag_d;
        end
    end

    // One-cycle power-off request after a write that sets the bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            off_pulse <= 1'b0;
        else
            off_pulse <= wr_aux2 & wbyte[OFF_BIT];
    end

    // Assemble the readable byte from the two stored bits.
    always_comb begin
        aux2_q           = '0;
        aux2_q[OFF_BIT]  = off_q;
        aux2_q[FLAG_BIT] = flag_q;
    end

    assign irq = flag_q & cfg_en;
endmodule

// File: rtl/aux_sys_regs.sv
// Module: system-control status byte with reset request pulse, and the LED
// word. Neither register responds to soft reset; only rst_n clears them.
module aux_sys_regs #(
    parameter int BYTE_W  = 8,
    parameter int LED_W   = 16,
    parameter int RST_BIT = 0,
    parameter logic [BYTE_W-1:0] STAT_VAL = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sys,
    input  logic              wr_led,
    input  logic [LED_W-1:0]  wword,
    output logic [BYTE_W-1:0] sys_q,
    output logic [LED_W-1:0]  led_q,
    output logic              rst_pulse
);
    logic sys_trig;
    assign sys_trig = wr_sys & wword[RST_BIT];

    // System-control status: loads the fixed status value on a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sys_q <= '0;
        else if (sys_trig)
            sys_q <= STAT_VAL;
    end

    // One-cycle reset request after a trigger write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_pulse <= 1'b0;
        else
            rst_pulse <= sys_trig;
    end

    // LED word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            led_q <= '0;
        else if (wr_led)
            led_q <= wword;
    end
endmodule

// File: rtl/aux_rd_mux.sv
// Module: registered AND-OR read multiplexer over a flattened value bus.
// Assumes sel is one-hot or zero; output is zero when rd_en is low.
module aux_rd_mux #(
    parameter int NUM    = 7,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic [NUM-1:0]        sel,
    input  logic [NUM*DATA_W-1:0] vals,
    output logic [DATA_W-1:0]     rdata
);
    logic [DATA_W-1:0] term [NUM];
    logic [DATA_W-1:0] muxed;

    for (genvar i = 0; i < NUM; i++) begin : g_term
        assign term[i] = vals[i*DATA_W +: DATA_W] & {DATA_W{sel[i]}};
    end

    // OR together the gated terms.
    always_comb begin
        muxed = '0;
        for (int i = 0; i < NUM; i++)
            muxed = muxed | term[i];
    end

    // Capture the read result for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= rd_en ? muxed : '0;
    end
endmodule

// File: rtl/aux_sysctl_regs.sv
// Module: top of the auxiliary system control register block. Decodes the
// one-hot select into write strobes, drops writes during soft reset, and
// gathers all registers for the read mux. Assumes sel is one-hot or zero.
module aux_sysctl_regs
    import aux_sysctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int LED_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic [NUM_REGS-1:0] sel,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                pwr_fail_in,
    output logic                pwr_irq,
    output logic                fdc_tc_pulse,
    output logic                pwr_off_req,
    output logic                sys_reset_req
);
    localparam int VALS_W = NUM_REGS * DATA_W;

    logic [NUM_REGS-1:0] wr_hit;
    logic [BYTE_W-1:0]   cfg_q, diag_q, modem_q, aux1_q, aux2_q, sys_q;
    logic [LED_W-1:0]    led_q;
    logic [VALS_W-1:0]   vals;

    assign wr_hit = (wr_en && !soft_rst) ? sel : '0;

    aux_byte_regs #(.BYTE_W(BYTE_W), .TC_BIT(AUX1_TC_BIT)) u_bytes (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_cfg   (wr_hit[IDX_CFG]),
        .wr_diag  (wr_hit[IDX_DIAG]),
        .wr_modem (wr_hit[IDX_MODEM]),
        .wr_aux1  (wr_hit[IDX_AUX1]),
        .wbyte    (wdata[BYTE_W-1:0]),
        .cfg_q    (cfg_q),
        .diag_q   (diag_q),
        .modem_q  (modem_q),
        .aux1_q   (aux1_q),
        .tc_pulse (fdc_tc_pulse)
    );

    aux_pwr_ctl #(
        .BYTE_W  (BYTE_W),
        .OFF_BIT (AUX2_OFF_BIT),
        .CLR_BIT (AUX2_CLR_BIT),
        .FLAG_BIT(AUX2_FLAG_BIT)
    ) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .wr_aux2   (wr_hit[IDX_AUX2]),
        .wbyte     (wdata[BYTE_W-1:0]),
        .pf_in     (pwr_fail_in),
        .cfg_en    (cfg_q[CFG_EN_BIT]),
        .aux2_q    (aux2_q),
        .irq       (pwr_irq),
        .off_pulse (pwr_off_req)
    );

    aux_sys_regs #(
        .BYTE_W  (BYTE_W),
        .LED_W   (LED_W),
        .RST_BIT (SYS_RST_BIT),
        .STAT_VAL(SYS_STAT_VAL)
    ) u_sys (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sys    (wr_hit[IDX_SYSCTL]),
        .wr_led    (wr_hit[IDX_LED]),
        .wword     (wdata[LED_W-1:0]),
        .sys_q     (sys_q),
        .led_q     (led_q),
        .rst_pulse (sys_reset_req)
    );

    // Zero-extend every register into its read slot.
    always_comb begin
        vals = '0;
        vals[IDX_CFG*DATA_W    +: DATA_W] = DATA_W'(cfg_q);
        vals[IDX_DIAG*DATA_W   +: DATA_W] = DATA_W'(diag_q);
        vals[IDX_MODEM*DATA_W  +: DATA_W] = DATA_W'(modem_q);
        vals[IDX_AUX1*DATA_W   +: DATA_W] = DATA_W'(aux1_q);
        vals[IDX_AUX2*DATA_W   +: DATA_W] = DATA_W'(aux2_q);
        vals[IDX_LED*DATA_W    +: DATA_W] = DATA_W'(led_q);
        vals[IDX_SYSCTL*DATA_W +: DATA_W] = DATA_W'(sys_q);
    end

    aux_rd_mux #(.NUM(NUM_REGS), .DATA_W(DATA_W)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .sel   (sel),
        .vals  (vals),
        .rdata (rdata)
    );
endmodule

// File: rtl/aux_sysctl_chk.sv
// Checker: temporal properties of the auxiliary system control block,
// observed at its ports. Bound to every instance of the top module.
module aux_sysctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic [6:0]  sel,
    input logic        wr_en,
    input logic        rd_en,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        pwr_irq,
    input logic        fdc_tc_pulse,
    input logic        pwr_off_req,
    input logic        sys_reset_req
);
    // R2: select is one-hot or idle.
    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R2: no read strobe, no read data.
    a_r2_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == 32'h0);

    // R3: strobe write produces the pulse next cycle.
    a_r3_tc_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst && sel[3] && wdata[1]) |=> fdc_tc_pulse);

    // R3: pulse only after a strobe write.
    a_r3_tc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fdc_tc_pulse |-> $past(wr_en && !soft_rst && sel[3] && wdata[1]));

    // R3: aux1 strobe bit always reads 0.
    a_r3_aux1_bit1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel[3]) |=> !rdata[1]);

    // R4: aux2 reads only bits 0 and 5.
    a_r4_aux2_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel[4]) |=> (rdata & 32'hFFFF_FFDE) == 32'h0);

    // R5: power-off pulse only after a power-off write.
    a_r5_off_cause: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off_req |-> $past(wr_en && !soft_rst && sel[4] && wdata[0]));

    // R8: reset request only after a trigger write.
    a_r8_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(wr_en && !soft_rst && sel[6] && wdata[0]));

    // R9: soft reset leaves no interrupt behind.
    a_r9_soft_irq: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !pwr_irq);
endmodule

bind aux_sysctl_regs aux_sysctl_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .sel           (sel),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .wdata         (wdata),
    .rdata         (rdata),
    .pwr_irq       (pwr_irq),
    .fdc_tc_pulse  (fdc_tc_pulse),
    .pwr_off_req   (pwr_off_req),
    .sys_reset_req (sys_reset_req)
);

// File: tb/test_aux_sysctl_regs.sv
// Bench: directed corner cases then seeded random traffic, every output
// compared each cycle against a model built from the requirements.
module test_aux_sysctl_regs;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [6:0]  sel = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwr_fail_in = 1'b0;
    logic        pwr_irq, fdc_tc_pulse, pwr_off_req, sys_reset_req;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic [7:0]  m_cfg = 0, m_diag = 0, m_modem = 0, m_aux1 = 0, m_sys = 0;
    logic [15:0] m_led = 0;
    logic        m_off = 0, m_flag = 0, m_pf_prev = 0;

    always #(CLK_P/2) clk = ~clk;

    aux_sysctl_regs i_aux_sysctl_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sel(sel),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .pwr_fail_in(pwr_fail_in), .pwr_irq(pwr_irq),
        .fdc_tc_pulse(fdc_tc_pulse), .pwr_off_req(pwr_off_req),
        .sys_reset_req(sys_reset_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [6:0] s);
        logic [31:0] v = '0;
        if (s[0]) v |= {24'h0, m_cfg};
        if (s[1]) v |= {24'h0, m_diag};
        if (s[2]) v |= {24'h0, m_modem};
        if (s[3]) v |= {24'h0, m_aux1};
        if (s[4]) v |= {24'h0, 2'b00, m_flag, 4'b0000, m_off};
        if (s[5]) v |= {16'h0, m_led};
        if (s[6]) v |= {24'h0, m_sys};
        return v;
    endfunction

    // One cycle: drive at a falling edge, update the model, check at the next.
    task automatic step(input logic [6:0] s, input logic w, input logic r,
                        input logic [31:0] d, input logic pf, input logic sr,
                        input string tag);
        logic [31:0] e_rd;
        logic e_tc, e_off, e_rst, evt, old_en, wv;
        sel = s; wr_en = w; rd_en = r; wdata = d; pwr_fail_in = pf; soft_rst = sr;
        e_rd   = r ? model_read(s) : 32'h0;
        wv     = w && !sr;
        e_tc   = wv && s[3] && d[1];
        e_off  = wv && s[4] && d[0];
        e_rst  = wv && s[6] && d[0];
        evt    = (pf != m_pf_prev);
        old_en = m_cfg[3];
        m_pf_prev = pf;
        if (sr) begin
            m_cfg = 0; m_modem = 0; m_aux1 = 0; m_off = 0; m_flag = 0;
        end else begin
            if (wv) begin
                if (s[0]) m_cfg = d[7:0];
                if (s[1]) m_diag = d[7:0];
                if (s[2]) m_modem = d[7:0];
                if (s[3]) m_aux1 = d[7:0] & 8'hFD;
                if (s[4]) begin
                    m_off = d[0];
                    if (d[1]) m_flag = 1'b0;
                end
                if (s[5]) m_led = d[15:0];
                if (s[6] && d[0]) m_sys = 8'h02;
            end
            if (evt) m_flag = pf & old_en;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, rdata, e_rd);
        check("R3 tc pulse", {31'h0, fdc_tc_pulse}, {31'h0, e_tc});
        check("R5 power-off pulse", {31'h0, pwr_off_req}, {31'h0, e_off});
        check("R8 reset pulse", {31'h0, sys_reset_req}, {31'h0, e_rst});
        check("R7 irq", {31'h0, pwr_irq}, {31'h0, m_flag & m_cfg[3]});
    endtask

    task automatic wr(input int idx, input logic [31:0] d, input string tag);
        step(7'(1 << idx), 1'b1, 1'b0, d, pwr_fail_in, 1'b0, tag);
    endtask

    task automatic rd(input int idx, input string tag);
        step(7'(1 << idx), 1'b0, 1'b1, 32'h0, pwr_fail_in, 1'b0, tag);
    endtask

    task automatic pf_set(input logic v, input string tag);
        step(7'h00, 1'b0, 1'b0, 32'h0, v, 1'b0, tag);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset rdata", rdata, 32'h0);
        check("R1 reset outs", {28'h0, pwr_irq, fdc_tc_pulse, pwr_off_req, sys_reset_req}, 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 7; i++) rd(i, "R1");

        // R2 plain registers and idle read
        wr(0, 32'hFFFF_FFA5, "R2"); wr(1, 32'h0000_003C, "R2");
        wr(2, 32'h1234_5696, "R2"); wr(5, 32'hDEAD_BEEF, "R2");
        rd(0, "R2"); rd(1, "R2"); rd(2, "R2"); rd(5, "R2");
        step(7'h02, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, "R2 idle");

        // R3 strobe bit not stored
        wr(3, 32'h0000_00FF, "R3"); rd(3, "R3");
        wr(3, 32'h0000_0002, "R3"); rd(3, "R3");

        // R6 gate sampled at input change
        wr(0, 32'h0, "R6"); pf_set(1'b1, "R6"); rd(4, "R6");
        pf_set(1'b0, "R6");
        wr(0, 32'h08, "R6"); rd(4, "R6");
        pf_set(1'b1, "R6"); rd(4, "R6");
        pf_set(1'b1, "R7"); wr(0, 32'h0, "R7"); wr(0, 32'h08, "R7");

        // R4 flag sticky, only bit0 stored, clear bit
        wr(4, 32'h0000_00FC, "R4"); rd(4, "R4");
        wr(4, 32'h0000_0002, "R4"); rd(4, "R4");

        // R5 power-off
        wr(4, 32'h0000_0001, "R5"); rd(4, "R5");

        // R10 input change beats clear
        pf_set(1'b0, "R10");
        step(7'h10, 1'b1, 1'b0, 32'h02, 1'b1, 1'b0, "R10");
        rd(4, "R10");

        // R8 system control
        wr(6, 32'hFFFF_FFFE, "R8"); rd(6, "R8");
        wr(6, 32'h0000_0001, "R8"); rd(6, "R8");

        // R9 soft reset keeps diag/LED/sysctl, drops coincident write
        wr(2, 32'h77, "R9"); wr(3, 32'h81, "R9");
        step(7'h02, 1'b1, 1'b0, 32'h11, 1'b1, 1'b1, "R9");
        for (int i = 0; i < 7; i++) rd(i, "R9");

        // seeded random traffic
        for (int k = 0; k < 500; k++) begin
            logic [6:0] s;
            logic pf, sr;
            s  = ($urandom % 8 == 0) ? 7'h00 : 7'(1 << ($urandom % 7));
            pf = ($urandom % 8 == 0) ? ~pwr_fail_in : pwr_fail_in;
            sr = ($urandom % 40 == 0);
            step(s, 1'($urandom), 1'($urandom), $urandom, pf, sr, "R2 random");
        end
        finish_run();
    end
endmodule